// File: doc/BRIEF.md
# Supply-Fault Processor Reset Generator

This block turns a digital "supply above trip level" indication into the reset line for a host processor. The line is active low and open drain. The block only ever pulls it low, and a weak pull-up raises it otherwise, so other reset sources can share the same wire. If the supply indication goes bad, the block pulls the line low as soon as the status has crossed the clock-domain synchronizer. When the supply comes back, the block keeps pulling low for a fixed number of clock cycles. Only after that does it release the line to the weak-high state. If the supply dips during that wait, the wait starts over.

While the reset is held, the block raises a lockout for the serial bus interface. It drops any register write strobe that the bus logic presents. A transaction that was running when lockout began is marked as spoiled. That transaction cannot write, even if lockout ends before the transaction does, and the block signals an abort for it until the bus logic goes idle. At power-up the reset is held from the start, and the full wait is applied once the supply is first seen as good.

Top module: `pwr_reset_guard`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `rst_drive_o` is 1 (line pulled low) and `bus_lockout_o` is 1.
- R2: When `supply_ok_i` goes to 0 before clock edge T, `rst_drive_o` is 1 after edge T+1 (two synchronizer flops, no further delay).
- R3: When `supply_ok_i` goes to 1 before edge T and stays at 1, `rst_drive_o` is still 1 after edge T+HOLD_CYCLES and is 0 after edge T+HOLD_CYCLES+1.
- R4: A drop of `supply_ok_i` during the hold interval restarts it. The release then follows the R3 timing, counted from the edge before which the supply was restored.
- R5: While the hold interval has expired and the supply is good, `rst_drive_o` is 0 (released to the weak pull-up).
- R6: `bus_lockout_o` always equals `rst_drive_o`.
- R7: `bus_wr_en_o` is 1 only when `bus_wr_req_i` is 1 and lockout is 0.
- R8: If lockout is 1 in any cycle while `bus_busy_i` is 1, then `bus_wr_en_o` stays 0 until `bus_busy_i` has been 0 for at least one clock edge, even after lockout ends.
- R9: `bus_abort_o` is 1 whenever `bus_busy_i` is 1 and either lockout is 1 or the current transaction is spoiled under R8.
- R10: At power-up with `supply_ok_i` at 0, the line stays pulled low for as long as the supply stays bad. The full R3 hold interval then applies from the first good supply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| supply_ok_i | input | 1 | Asynchronous supply status, 1 = above trip level |
| rst_drive_o | output | 1 | Open-drain enable, 1 = pull processor reset line low |
| bus_lockout_o | output | 1 | Serial bus lockout, 1 = transactions blocked |
| bus_busy_i | input | 1 | Bus logic has a transaction in progress |
| bus_wr_req_i | input | 1 | Bus logic requests a register write this cycle |
| bus_wr_en_o | output | 1 | Qualified register write strobe |
| bus_abort_o | output | 1 | Current transaction must be abandoned |

## Verification
Two functions can coincide in one cycle. The first is the lockout taking effect. The second is a write request from a transaction that is already under way. The bench starts a transaction, keeps the write request high and drops the supply. It then checks that the write strobe falls in the same cycle in which the reset drive rises, and that abort is raised in that cycle. It also lets the supply recover while the transaction is still busy. It then checks that the release of the reset does not let the spoiled transaction write, and that only a fresh transaction, started after an idle edge, can write again.

// File: rtl/pwr_reset_guard_pkg.sv
// Package: shared settings and types for the supply-fault reset generator.
// Assumes a clock of about 1 MHz for the default hold of 50 ms.
package pwr_reset_guard_pkg;

    localparam int unsigned DEF_HOLD_CYCLES = 50000;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Hold timer state: holding reset, or released (supply good).
    typedef enum logic {
        HOLD_ST_ACTIVE  = 1'b1,
        HOLD_ST_RELEASE = 1'b0
    } hold_state_e;

endpackage

// File: rtl/prg_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2 and that the input is a slow level, not a pulse.
// Reset loads RST_VAL into every stage.
module prg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/prg_hold_timer.sv
// Module: reset hold timer.
// The hold state is set by reset and whenever the synchronized supply is
// bad. It is cleared after HOLD_CYCLES consecutive edges with good supply.
// Any bad supply sample restarts the count. The reset request output also
// covers the bad-supply cycles directly, so assertion adds no extra delay.
module prg_hold_timer
    import pwr_reset_guard_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good_i,
    output logic rst_req_o
);

    localparam int unsigned CNT_W   = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    hold_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    // Count good-supply edges while holding; restart on any bad sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_ST_ACTIVE;
            cnt_q   <= '0;
        end else if (!supply_good_i) begin
            state_q <= HOLD_ST_ACTIVE;
            cnt_q   <= '0;
        end else if (state_q == HOLD_ST_ACTIVE) begin
            if (cnt_q == CNT_LAST) begin
                state_q <= HOLD_ST_RELEASE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Request reset while holding or while the supply is seen as bad.
    always_comb begin
        rst_req_o = (state_q == HOLD_ST_ACTIVE) || !supply_good_i;
    end

endmodule

// File: rtl/prg_bus_gate.sv
// Module: serial bus lockout gate.
// Blocks write strobes while lockout is high. A transaction that sees
// lockout at any point is marked spoiled until the bus logic goes idle.
// Assumes bus_busy_i stays high for the whole of one transaction.
module prg_bus_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lockout_i,
    input  logic busy_i,
    input  logic wr_req_i,
    output logic wr_en_o,
    output logic abort_o
);

    logic spoiled_q;

    // Remember that the running transaction was hit by lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spoiled_q <= 1'b0;
        end else if (!busy_i) begin
            spoiled_q <= 1'b0;
        end else if (lockout_i) begin
            spoiled_q <= 1'b1;
        end
    end

    // Qualify the write and flag the abort.
    always_comb begin
        wr_en_o = wr_req_i && !lockout_i && !spoiled_q;
        abort_o = busy_i && (lockout_i || spoiled_q);
    end

endmodule

// File: rtl/pwr_reset_guard.sv
// Module: supply-fault processor reset generator (top).
// Chain: synchronizer -> hold timer -> open-drain enable and bus lockout.
// Assumes the pad applies the weak pull-up; rst_drive_o only enables
// the low-side driver.
module pwr_reset_guard
    import pwr_reset_guard_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEF_HOLD_CYCLES,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    output logic rst_drive_o,
    output logic bus_lockout_o,
    input  logic bus_busy_i,
    input  logic bus_wr_req_i,
    output logic bus_wr_en_o,
    output logic bus_abort_o
);

    logic supply_good;
    logic rst_req;

    prg_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (supply_ok_i),
        .q_o   (supply_good)
    );

    prg_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_good_i (supply_good),
        .rst_req_o     (rst_req)
    );

    prg_bus_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .lockout_i (rst_req),
        .busy_i    (bus_busy_i),
        .wr_req_i  (bus_wr_req_i),
        .wr_en_o   (bus_wr_en_o),
        .abort_o   (bus_abort_o)
    );

    // Drive the reset line and the lockout from the same request.
    always_comb begin
        rst_drive_o   = rst_req;
        bus_lockout_o = rst_req;
    end

endmodule

// File: rtl/pwr_reset_guard_chk.sv
// Checker: temporal properties of the reset generator, bound to the top.
// A small counter of edges since reset limits how far back $past looks.
module pwr_reset_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic rst_drive_o,
    input logic bus_lockout_o,
    input logic bus_busy_i,
    input logic bus_wr_req_i,
    input logic bus_wr_en_o,
    input logic bus_abort_o
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R2
    drop_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !$past(supply_ok_i, 2)) |-> rst_drive_o);

    // R3
    release_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $fell(rst_drive_o)) |-> ($past(supply_ok_i) && $past(supply_ok_i, 2)));

    // R7
    no_write_in_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lockout_o |-> !bus_wr_en_o);

    // R7
    write_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en_o |-> bus_wr_req_i);

    // R8
    spoiled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(bus_busy_i) && $past(bus_lockout_o) && bus_busy_i) |-> !bus_wr_en_o);

    // R9
    abort_in_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy_i && bus_lockout_o) |-> bus_abort_o);

    // R9
    abort_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort_o |-> bus_busy_i);

endmodule

bind pwr_reset_guard pwr_reset_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok_i),
    .rst_drive_o   (rst_drive_o),
    .bus_lockout_o (bus_lockout_o),
    .bus_busy_i    (bus_busy_i),
    .bus_wr_req_i  (bus_wr_req_i),
    .bus_wr_en_o   (bus_wr_en_o),
    .bus_abort_o   (bus_abort_o)
);

// File: tb/pwr_reset_guard_bench.sv
// Directed bench for the reset generator, one task per scenario.
module pwr_reset_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic busy = 1'b0;
    logic wr_req = 1'b0;
    logic drive, lockout, wr_en, abort_s;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_reset_guard #(
        .HOLD_CYCLES (HOLD),
        .SYNC_STAGES (2)
    ) u_pwr_reset_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok_i   (supply_ok),
        .rst_drive_o   (drive),
        .bus_lockout_o (lockout),
        .bus_busy_i    (busy),
        .bus_wr_req_i  (wr_req),
        .bus_wr_en_o   (wr_en),
        .bus_abort_o   (abort_s)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance n rising edges, ending at a falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Supply was just raised at a falling edge: check the exact release edge.
    task automatic expect_release(input string req);
        step(HOLD + 1);
        check(req, drive, 1'b1);
        check({req, " lockout (R6)"}, lockout, 1'b1);
        step(1);
        check(req, drive, 1'b0);
        check({req, " released (R5)"}, drive, 1'b0);
        check({req, " lockout (R6)"}, lockout, 1'b0);
    endtask

    task automatic t_reset_powerup();
        @(negedge clk);
        step(3);
        check("R1 drive in reset", drive, 1'b1);
        check("R1 lockout in reset", lockout, 1'b1);
        rst_n = 1'b1;
        step(1);
        check("R1 drive after reset", drive, 1'b1);
        check("R1 lockout after reset", lockout, 1'b1);
        step(30);
        check("R10 held while supply bad", drive, 1'b1);
        supply_ok = 1'b1;
        expect_release("R10 R3 powerup hold");
    endtask

    task automatic t_drop();
        supply_ok = 1'b0;
        step(1);
        check("R2 not yet through sync", drive, 1'b0);
        step(1);
        check("R2 asserted after two edges", drive, 1'b1);
        check("R6 lockout on drop", lockout, 1'b1);
        step(4);
        check("R2 held while low", drive, 1'b1);
        supply_ok = 1'b1;
        expect_release("R3 after drop");
    endtask

    task automatic t_dip();
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(10);
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        expect_release("R4 restart on dip");
    endtask

    task automatic t_bus();
        busy = 1'b1;
        wr_req = 1'b1;
        step(1);
        check("R7 write passes when free", wr_en, 1'b1);
        check("R9 no abort when free", abort_s, 1'b0);
        supply_ok = 1'b0;
        step(1);
        check("R7 write before lockout", wr_en, 1'b1);
        step(1);
        check("R7 write blocked same cycle", wr_en, 1'b0);
        check("R9 abort in lockout", abort_s, 1'b1);
        supply_ok = 1'b1;
        expect_release("R3 with bus busy");
        check("R8 spoiled write stays blocked", wr_en, 1'b0);
        check("R9 abort while spoiled", abort_s, 1'b1);
        busy = 1'b0;
        step(1);
        check("R9 no abort when idle", abort_s, 1'b0);
        busy = 1'b1;
        step(1);
        check("R8 new transaction writes", wr_en, 1'b1);
        check("R9 new transaction no abort", abort_s, 1'b0);
        wr_req = 1'b0;
        step(1);
        check("R7 no request no write", wr_en, 1'b0);
        busy = 1'b0;
    endtask

    initial begin
        t_reset_powerup();
        t_drop();
        t_dip();
        t_bus();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule